// File: doc/BRIEF.md
# Serial DAC Command Writer

This peripheral sits on a simple register bus and sends 32-bit command words to an external serial digital-to-analog converter over three wires: an active-low frame strobe, a serial clock and a data line. Software builds the whole command word. A single write to the command register starts a framed transfer. The frame strobe drops, then 32 bits go out, most significant bit first. The strobe then rises again and stays high for a guaranteed gap.

The converter captures data on each falling serial clock edge and carries out the command on the 32nd falling edge. The block therefore drives each new data bit on the rising edge, so the bit is settled well before the converter samples it. In the command word, bits 27:24 hold the command code, bits 23:20 the channel address, bits 19:4 a 16-bit sample and bits 19:8 a 12-bit sample. The block passes these bits through unchanged. A divider register sets the serial clock speed, from half the system clock down to much slower rates, to suit slower converters. Software polls the command register. It reads nonzero while a frame is in flight and zero once the block can take a new word.

Top module: `dac_serial_writer`

## Requirements
- R1: After reset, dac_sync_n and dac_sclk are 1, dac_sdo is 0, the divider reads 0 and the block is idle.
- R2: A write to address 0 while idle launches a frame. From the cycle after the write edge, dac_sync_n is 0 for exactly 64*(D+1) cycles, where D is the divider value held at launch.
- R3: During the frame, bit 31-i of the written word is on dac_sdo for the 2*(D+1) cycles of serial bit i, bit 31 first. dac_sdo changes only when dac_sclk rises or when the frame starts, and it is 0 whenever dac_sync_n is 1.
- R4: dac_sclk idles at 1. In each bit period it is 1 for D+1 cycles and then 0 for D+1 cycles, giving a period of 2*(D+1) system clocks, so each frame has exactly 32 falling edges.
- R5: Reading address 0 returns 1 (bit 0) from the cycle after launch until the frame and its gap finish, and returns 0 when idle.
- R6: A write to address 1 while idle loads bits 7:0 into the divider, and reading address 1 returns that value zero-extended. Reads of any other address return 0.
- R7: Writes to address 0 or address 1 while busy are ignored. The frame in flight, the divider and later frames are unaffected.
- R8: After the last bit, dac_sync_n returns to 1 and busy stays set for GAP_CYC more cycles. A new frame therefore never starts with dac_sync_n having been high for fewer than GAP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | ADDR_W | Write address (0 command, 1 divider) |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read address, combinational read |
| bus_rdata | output | 32 | Read data (busy flag or divider) |
| dac_sync_n | output | 1 | Active-low frame strobe |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdo | output | 1 | Serial data, MSB first |

## Verification
Two events can share a cycle: a new command write can arrive in the very cycle the previous frame's gap ends, and a write can arrive while a frame is still in flight. The bench holds the write strobe high every cycle with changing data across several whole frames. The only write that may launch is the first one after busy is seen to clear. Every other word and every divider write must leave no trace on the lines. A behavioural model predicts the strobe, clock, data bit and busy read from elapsed cycles alone, and the bench compares the design against it on every cycle.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_CNT_W = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] cmd_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic sync_n;
        logic sclk;
        logic sdo;
    } line_bundle_t;

    function automatic logic last_bit(input logic [BIT_CNT_W-1:0] idx);
        return idx == BIT_CNT_W'(WORD_W - 1);
    endfunction
endpackage

// File: rtl/dsw_regs.sv
module dsw_regs #(
    parameter int ADDR_W = 2,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DIV_W-1:0]  wdata_div,
    input  logic [ADDR_W-1:0] bus_raddr,
    input  logic              busy,
    output logic              launch,
    output logic [DIV_W-1:0]  div_q,
    output dsw_pkg::cmd_word_t rdata
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(1);

    logic wr_ok;
    assign wr_ok  = bus_wr && !busy;
    assign launch = wr_ok && (bus_waddr == CMD_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (wr_ok && bus_waddr == DIV_ADDR) begin
            div_q <= wdata_div;
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_raddr == CMD_ADDR) begin
            rdata[0] = busy;
        end else if (bus_raddr == DIV_ADDR) begin
            rdata[DIV_W-1:0] = div_q;
        end
    end
endmodule

// File: rtl/dsw_clkgen.sv
module dsw_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);
    logic [DIV_W-1:0] cnt;

    assign half_tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || half_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dsw_shifter.sv
module dsw_shifter
    import dsw_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      launch,
    input  cmd_word_t word,
    input  logic      half_tick,
    output logic      run,
    output logic      busy,
    output line_bundle_t lines
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    wr_state_e            state;
    cmd_word_t            sreg;
    logic [BIT_CNT_W-1:0] bit_idx;
    logic [GAP_W-1:0]     gap_cnt;
    logic                 sync_n_q;
    logic                 sclk_q;

    assign run  = (state == ST_SHIFT);
    assign busy = (state != ST_IDLE);

    always_comb begin
        lines.sync_n = sync_n_q;
        lines.sclk   = sclk_q;
        lines.sdo    = !sync_n_q && sreg[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sreg     <= '0;
            bit_idx  <= '0;
            gap_cnt  <= '0;
            sync_n_q <= 1'b1;
            sclk_q   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state    <= ST_SHIFT;
                        sreg     <= word;
                        bit_idx  <= '0;
                        sync_n_q <= 1'b0;
                        sclk_q   <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (half_tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                        end else if (last_bit(bit_idx)) begin
                            state    <= ST_GAP;
                            sync_n_q <= 1'b1;
                            sclk_q   <= 1'b1;
                            gap_cnt  <= '0;
                        end else begin
                            sclk_q  <= 1'b1;
                            sreg    <= {sreg[WORD_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
    import dsw_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [31:0]       bus_rdata,
    output logic              dac_sync_n,
    output logic              dac_sclk,
    output logic              dac_sdo
);
    logic             busy;
    logic             launch;
    logic             run;
    logic             half_tick;
    logic [DIV_W-1:0] div_q;
    line_bundle_t     lines;

    dsw_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .wdata_div (bus_wdata[DIV_W-1:0]),
        .bus_raddr (bus_raddr),
        .busy      (busy),
        .launch    (launch),
        .div_q     (div_q),
        .rdata     (bus_rdata)
    );

    dsw_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .div       (div_q),
        .half_tick (half_tick)
    );

    dsw_shifter #(.GAP_CYC(GAP_CYC)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .word      (bus_wdata),
        .half_tick (half_tick),
        .run       (run),
        .busy      (busy),
        .lines     (lines)
    );

    assign dac_sync_n = lines.sync_n;
    assign dac_sclk   = lines.sclk;
    assign dac_sdo    = lines.sdo;
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
    parameter int GAP_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic sync_n,
    input logic sclk,
    input logic sdo
);
    logic [15:0] high_cnt;
    logic [5:0]  fall_cnt;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= 16'(GAP_CYC);
            fall_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            if (!sync_n) high_cnt <= '0;
            else if (high_cnt < 16'(GAP_CYC)) high_cnt <= high_cnt + 1'b1;
            if (sync_n) fall_cnt <= '0;
            else if (sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sync_n && sclk && !sdo)); // R1
    AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (rst)
        !sync_n |-> busy); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && $past(!sync_n) && !$rose(sclk)) |-> $stable(sdo)); // R3
    AST_FALL_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (fall_cnt == 6'd32)); // R4
    AST_SYNC_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_n) |-> (high_cnt >= 16'(GAP_CYC))); // R8
endmodule

bind dac_serial_writer dsw_checker #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .sync_n (dac_sync_n),
    .sclk   (dac_sclk),
    .sdo    (dac_sdo)
);

// File: tb/dac_serial_writer_test.sv
module dac_serial_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        dac_sync_n, dac_sclk, dac_sdo;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit          m_active = 0;
    int          m_k = 0;
    int          m_d = 0;
    int          m_div = 0;
    logic [31:0] m_cmd = '0;
    int          launches = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_writer #(.ADDR_W(2), .DIV_W(8), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_k = 0; m_div = 0;
        end else if (m_active) begin
            m_k = m_k + 1;
            if (m_k == 64 * (m_d + 1) + GAP) m_active = 0;
        end else if (bus_wr && bus_waddr == 2'd0) begin
            m_active = 1; m_k = 0; m_d = m_div; m_cmd = bus_wdata;
            launches = launches + 1;
        end else if (bus_wr && bus_waddr == 2'd1) begin
            m_div = int'(bus_wdata[7:0]);
        end
    end

    task automatic chk1(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            fails++; vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
        end
        if (cycles > 1) begin
            logic e_sync, e_sclk, e_sdo;
            logic [31:0] e_rd;
            int half, bidx;
            e_sync = 1; e_sclk = 1; e_sdo = 0;
            if (m_active && m_k < 64 * (m_d + 1)) begin
                half = m_k / (m_d + 1);
                bidx = half / 2;
                e_sync = 0;
                e_sclk = (half % 2 == 0);
                e_sdo = m_cmd[31 - bidx];
            end
            chk1(rst ? "R1 sync" : "R2 sync", dac_sync_n, e_sync);
            chk1(rst ? "R1 sclk" : "R4 sclk", dac_sclk, e_sclk);
            chk1(rst ? "R1 sdo" : "R3 sdo", dac_sdo, e_sdo);
            if (bus_raddr == 2'd0) e_rd = m_active ? 32'd1 : 32'd0;
            else if (bus_raddr == 2'd1) e_rd = 32'(m_div);
            else e_rd = 32'd0;
            vectors++;
            if (bus_rdata !== e_rd) begin
                fails++;
                $display("FAIL %s cycle %0d: actual %h expected %h",
                         (bus_raddr == 2'd0) ? "R5 busy" : "R6 rdata", cycles, bus_rdata, e_rd);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1; bus_waddr = a; bus_wdata = d;
        tick(1);
        bus_wr = 0;
    endtask

    initial begin
        tick(4);
        rst = 0;
        tick(2);
        // R1 reset divider readback
        bus_raddr = 2'd1; tick(2); bus_raddr = 2'd0;
        // R2/R3/R4 full-rate frame
        wr(2'd0, 32'hA5C3_0F1E);
        tick(80);
        // R6 divider write, readback, then slow frame
        wr(2'd1, 32'hFFFF_FF03);
        bus_raddr = 2'd1; tick(2); bus_raddr = 2'd3; tick(2); bus_raddr = 2'd0;
        wr(2'd0, 32'h0384_FFF0);
        tick(10);
        // R7 writes while busy ignored
        wr(2'd0, 32'hFFFF_FFFF);
        tick(7);
        wr(2'd1, 32'h0000_0007);
        bus_raddr = 2'd1; tick(3); bus_raddr = 2'd0;
        tick(300);
        // R8 and R7: write strobe held every cycle, back-to-back frames
        bus_wr = 1; bus_waddr = 2'd0;
        for (int i = 0; i < 700; i++) begin
            bus_wdata = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
            tick(1);
        end
        bus_wr = 0;
        tick(300);
        // R6 slower divider, single frame with 12-bit style payload
        wr(2'd1, 32'h0000_0000);
        wr(2'd1, 32'h0000_0001);
        wr(2'd0, 32'h0325_ABC0);
        tick(200);
        if (launches < 5) begin
            fails++; vectors++;
            $display("FAIL R2 launches: actual %0d expected >=5", launches);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule